// File: doc/BRIEF.md
# Flash Access Protection Controller

This block keeps the write-once protection state that decides whether an on-chip flash may be read by anything other than its own code. It stores a global lock bit, a debug lock bit, and a chain of sixteen pairs of "open" and "close" bits. Every stored bit starts in the erased state (1). Programming can only drive a bit to 0, and it must follow a fixed order, so protection can be lifted and then restored up to sixteen times over the life of the part. A single volatile temporary-unlock bit also suspends protection. Only code fetched from the internal flash can write it.

A program request names a target word and carries a data word. Each 0 in the data asks for the matching stored bit to be cleared, and each 1 leaves its bit alone. If a request breaks the ordering rules, the whole request is dropped and a sticky error flag is raised. A full-erase command puts the non-volatile bits back to their delivery state. The protection-in-force output is derived combinationally from the stored bits. This model has no storage that survives power loss, so reset loads the delivery state.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset the global bit and the debug bit read 1, open_bits and close_bits read all ones (FFFFh), tmp_unlock reads 0, seq_err reads 0 and prot_active reads 0.
- R2: A program request updates its target on the next clock edge. Target codes: 0 is the control word (data bit 0 is the global bit, data bit 1 is the debug bit), 1 is open_bits, 2 is close_bits, 3 changes nothing and raises no error. Each target bit becomes old AND data, so a 1 in the data never turns a 0 back into 1.
- R3: Open bit 0 may be cleared only if the global bit and the debug bit are both already 0.
- R4: Open bit x, for x above 0, may be cleared only if close bit x-1 is already 0.
- R5: Close bit x may be cleared only if open bit x is already 0.
- R6: If any bit of a request breaks R3, R4 or R5, no stored bit changes and seq_err becomes 1. seq_err stays 1 until a cycle with stat_rd high, after which it reads 0, unless a new violation arrives in that same cycle.
- R7: prot_active is 1 exactly when the global bit is 0, no pair is lifting (pair x lifts when open bit x is 0 and close bit x is 1), and tmp_unlock is 0. It follows the stored bits combinationally.
- R8: A write to tmp_unlock takes effect on the next edge only while fetch_internal is 1. When fetch_internal is 0 the write is ignored.
- R9: erase_req sets every non-volatile bit to 1 and clears tmp_unlock on the next edge. It takes priority over a program request or a tmp_unlock write in the same cycle, and such a program request raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_valid | input | 1 | Program request strobe |
| prog_tgt | input | 2 | Target word code for the program request |
| prog_data | input | 16 | Program data; a 0 clears the matching bit |
| erase_req | input | 1 | Full-erase command |
| stat_rd | input | 1 | Status read; clears seq_err afterwards |
| tmp_wr | input | 1 | Write strobe for the temporary-unlock bit |
| tmp_wr_val | input | 1 | Value for the temporary-unlock bit |
| fetch_internal | input | 1 | 1 while the current fetch comes from internal flash |
| glob_bit | output | 1 | Stored global lock bit (0 = programmed) |
| dbg_bit | output | 1 | Stored debug lock bit (0 = programmed) |
| open_bits | output | 16 | Stored open (disable) chain |
| close_bits | output | 16 | Stored close (enable) chain |
| tmp_unlock | output | 1 | Volatile temporary-unlock bit |
| seq_err | output | 1 | Sticky ordering-violation flag |
| prot_active | output | 1 | Access protection currently in force |

## Verification
The chain is first walked through all sixteen lift-and-restore steps with single-bit requests. This shows that each pair lifts and restores protection at the expected step, and that prot_active toggles with each step. Out-of-order requests are then aimed at each rule in turn: open 0 before both locks, close x before open x, and open x before close x-1. Some of these are mixed into multi-bit words, which separates rejection of the whole request from rejection of single bits. Constrained random requests with biased single-bit clears, plus random erases, status reads and unlock writes from both fetch sources, then cover the mixes of states and commands that the directed cases miss.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_OPEN  = 2'd1,
    TGT_CLOSE = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  localparam int unsigned CTRL_GLOB_POS = 0;
  localparam int unsigned CTRL_DBG_POS  = 1;
endpackage

// File: rtl/fgc_rst_sync.sv
module fgc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fgc_order_check.sv
module fgc_order_check
  import fgc_pkg::*;
#(
  parameter int unsigned N_PAIRS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_tgt,
  input  logic [N_PAIRS-1:0] req_data,
  input  logic               cur_glob,
  input  logic               cur_dbg,
  input  logic [N_PAIRS-1:0] cur_open,
  input  logic [N_PAIRS-1:0] cur_close,
  output logic               viol
);
  logic               hit_open, hit_close;
  logic [N_PAIRS-1:0] clr_open, clr_close;
  logic [N_PAIRS-1:0] bad_open, bad_close;

  assign hit_open  = req_valid && (tgt_e'(req_tgt) == TGT_OPEN);
  assign hit_close = req_valid && (tgt_e'(req_tgt) == TGT_CLOSE);
  assign clr_open  = hit_open  ? (cur_open  & ~req_data) : '0;
  assign clr_close = hit_close ? (cur_close & ~req_data) : '0;

  for (genvar x = 0; x < N_PAIRS; x++) begin : g_rule
    if (x == 0) begin : g_head
      // first open bit needs both lock bits programmed
      assign bad_open[x] = clr_open[x] & (cur_glob | cur_dbg);
    end else begin : g_link
      // later open bits need the previous close bit programmed
      assign bad_open[x] = clr_open[x] & cur_close[x-1];
    end
    assign bad_close[x] = clr_close[x] & cur_open[x];
  end

  assign viol = (|bad_open) | (|bad_close);

  // a control-word or reserved request never violates ordering (R2)
  p_ctrl_no_viol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_tgt == 2'd0 || req_tgt == 2'd3)) |-> !viol);
endmodule

// File: rtl/fgc_nv_store.sv
module fgc_nv_store
  import fgc_pkg::*;
#(
  parameter int unsigned N_PAIRS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_valid,
  input  logic [1:0]         prog_tgt,
  input  logic [N_PAIRS-1:0] prog_data,
  input  logic               erase_req,
  input  logic               stat_rd,
  input  logic               viol,
  output logic               glob_q,
  output logic               dbg_q,
  output logic [N_PAIRS-1:0] open_q,
  output logic [N_PAIRS-1:0] close_q,
  output logic               err_q
);
  localparam logic [N_PAIRS-1:0] ERASED = {N_PAIRS{1'b1}};

  logic               glob_d, dbg_d, err_d;
  logic [N_PAIRS-1:0] open_d, close_d;
  logic               accept, upd_en;

  assign accept = prog_valid && !erase_req && !viol;
  assign upd_en = erase_req || prog_valid || stat_rd;

  always_comb begin
    glob_d  = glob_q;
    dbg_d   = dbg_q;
    open_d  = open_q;
    close_d = close_q;
    err_d   = err_q;
    if (erase_req) begin
      glob_d  = 1'b1;
      dbg_d   = 1'b1;
      open_d  = ERASED;
      close_d = ERASED;
    end else if (accept) begin
      unique case (tgt_e'(prog_tgt))
        TGT_CTRL: begin
          glob_d = glob_q & prog_data[CTRL_GLOB_POS];
          dbg_d  = dbg_q  & prog_data[CTRL_DBG_POS];
        end
        TGT_OPEN:  open_d  = open_q  & prog_data;
        TGT_CLOSE: close_d = close_q & prog_data;
        default: ;
      endcase
    end
    if (prog_valid && !erase_req && viol) err_d = 1'b1;
    else if (stat_rd)                     err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q  <= 1'b1;
      dbg_q   <= 1'b1;
      open_q  <= ERASED;
      close_q <= ERASED;
      err_q   <= 1'b0;
    end else if (upd_en) begin
      glob_q  <= glob_d;
      dbg_q   <= dbg_d;
      open_q  <= open_d;
      close_q <= close_d;
      err_q   <= err_d;
    end
  end

  // without erase, no stored bit ever returns from 0 to 1 (R2)
  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_req |=> (((open_q & ~$past(open_q)) == '0) &&
                    ((close_q & ~$past(close_q)) == '0) &&
                    !(glob_q && !$past(glob_q)) && !(dbg_q && !$past(dbg_q))));

  // open bit 0 programmed implies both lock bits programmed (R3)
  p_head_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q[0] |-> (!glob_q && !dbg_q));

  // a programmed open bit x>0 implies close bit x-1 programmed (R4)
  p_link_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~open_q[N_PAIRS-1:1] & close_q[N_PAIRS-2:0]) == '0));

  // a programmed close bit implies its open bit programmed (R5)
  p_pair_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~close_q & open_q) == '0));

  // a rejected request leaves the chains alone and flags an error (R6)
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && viol && !erase_req) |=>
      (err_q && $stable(open_q) && $stable(close_q)));

  // erase restores the delivery state (R9)
  p_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> (glob_q && dbg_q && open_q == ERASED && close_q == ERASED));
endmodule

// File: rtl/fgc_tmp_reg.sv
module fgc_tmp_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic wr_val,
  input  logic fetch_internal,
  input  logic erase_req,
  output logic tmp_q
);
  logic wr_en, tmp_d;

  assign wr_en = erase_req || (wr_req && fetch_internal);
  assign tmp_d = erase_req ? 1'b0 : wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmp_q <= 1'b0;
    else if (wr_en) tmp_q <= tmp_d;
  end

  // writes from outside internal flash are dropped (R8)
  p_foreign_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_internal && !erase_req) |=> $stable(tmp_q));

  // erase always clears the volatile bit (R9)
  p_erase_tmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !tmp_q);
endmodule

// File: rtl/fgc_eval.sv
module fgc_eval #(
  parameter int unsigned N_PAIRS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_bit,
  input  logic [N_PAIRS-1:0] open_bits,
  input  logic [N_PAIRS-1:0] close_bits,
  input  logic               tmp_unlock,
  output logic               prot_active
);
  logic [N_PAIRS-1:0] lift;

  for (genvar x = 0; x < N_PAIRS; x++) begin : g_lift
    assign lift[x] = !open_bits[x] && close_bits[x];
  end

  assign prot_active = !glob_bit && (lift == '0) && !tmp_unlock;

  // ordering keeps at most one pair lifting at a time (R7)
  p_single_lift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lift));

  // the volatile bit always suspends protection (R7)
  p_tmp_suspends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_unlock |-> !prot_active);
endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import fgc_pkg::*;
#(
  parameter int unsigned N_PAIRS   = 16,
  parameter int unsigned RST_SYNCS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_valid,
  input  logic [1:0]         prog_tgt,
  input  logic [N_PAIRS-1:0] prog_data,
  input  logic               erase_req,
  input  logic               stat_rd,
  input  logic               tmp_wr,
  input  logic               tmp_wr_val,
  input  logic               fetch_internal,
  output logic               glob_bit,
  output logic               dbg_bit,
  output logic [N_PAIRS-1:0] open_bits,
  output logic [N_PAIRS-1:0] close_bits,
  output logic               tmp_unlock,
  output logic               seq_err,
  output logic               prot_active
);
  logic rst_int_n;
  logic viol;

  fgc_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fgc_order_check #(.N_PAIRS(N_PAIRS)) u_order (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (prog_valid),
    .req_tgt   (prog_tgt),
    .req_data  (prog_data),
    .cur_glob  (glob_bit),
    .cur_dbg   (dbg_bit),
    .cur_open  (open_bits),
    .cur_close (close_bits),
    .viol      (viol)
  );

  fgc_nv_store #(.N_PAIRS(N_PAIRS)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .prog_valid (prog_valid),
    .prog_tgt   (prog_tgt),
    .prog_data  (prog_data),
    .erase_req  (erase_req),
    .stat_rd    (stat_rd),
    .viol       (viol),
    .glob_q     (glob_bit),
    .dbg_q      (dbg_bit),
    .open_q     (open_bits),
    .close_q    (close_bits),
    .err_q      (seq_err)
  );

  fgc_tmp_reg u_tmp (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .wr_req         (tmp_wr),
    .wr_val         (tmp_wr_val),
    .fetch_internal (fetch_internal),
    .erase_req      (erase_req),
    .tmp_q          (tmp_unlock)
  );

  fgc_eval #(.N_PAIRS(N_PAIRS)) u_eval (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .glob_bit    (glob_bit),
    .open_bits   (open_bits),
    .close_bits  (close_bits),
    .tmp_unlock  (tmp_unlock),
    .prot_active (prot_active)
  );
endmodule

// File: tb/tb_flash_guard_ctrl.sv
`timescale 1ns/1ps
module tb_flash_guard_ctrl;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         prog_valid, erase_req, stat_rd, tmp_wr, tmp_wr_val, fetch_internal;
  logic [1:0]   prog_tgt;
  logic [N-1:0] prog_data;
  logic         glob_bit, dbg_bit, tmp_unlock, seq_err, prot_active;
  logic [N-1:0] open_bits, close_bits;

  always #2.5 clk = ~clk;

  flash_guard_ctrl dut (
    .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_tgt(prog_tgt),
    .prog_data(prog_data), .erase_req(erase_req), .stat_rd(stat_rd),
    .tmp_wr(tmp_wr), .tmp_wr_val(tmp_wr_val), .fetch_internal(fetch_internal),
    .glob_bit(glob_bit), .dbg_bit(dbg_bit), .open_bits(open_bits),
    .close_bits(close_bits), .tmp_unlock(tmp_unlock), .seq_err(seq_err),
    .prot_active(prot_active)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic         m_glob, m_dbg, m_tmp, m_err;
  logic [N-1:0] m_open, m_close;

  function automatic logic ordering_broken(input logic [1:0] tgt, input logic [N-1:0] d);
    logic bad = 1'b0;
    for (int x = 0; x < N; x++) begin
      if (tgt == 2'd1 && m_open[x] && !d[x]) begin
        if (x == 0) bad |= (m_glob || m_dbg);        // R3
        else        bad |= m_close[x-1];             // R4
      end
      if (tgt == 2'd2 && m_close[x] && !d[x]) bad |= m_open[x]; // R5
    end
    return bad;
  endfunction

  function automatic logic prot_expect();
    logic any_lift = 1'b0;
    for (int x = 0; x < N; x++) any_lift |= (!m_open[x] && m_close[x]);
    return !m_glob && !any_lift && !m_tmp;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "glob_bit", 32'(glob_bit), 32'(m_glob));
    check(req, "dbg_bit", 32'(dbg_bit), 32'(m_dbg));
    check(req, "open_bits", 32'(open_bits), 32'(m_open));
    check(req, "close_bits", 32'(close_bits), 32'(m_close));
    check(req, "tmp_unlock", 32'(tmp_unlock), 32'(m_tmp));
    check(req, "seq_err", 32'(seq_err), 32'(m_err));
    check(req, "prot_active", 32'(prot_active), 32'(prot_expect()));
  endtask

  // one clock cycle of stimulus, reference update, then compare
  task automatic cycle(input logic pv, input logic [1:0] tg, input logic [N-1:0] d,
                       input logic er, input logic rd, input logic tw, input logic tv,
                       input logic fi, input string req);
    logic bad;
    @(negedge clk);
    prog_valid = pv; prog_tgt = tg; prog_data = d; erase_req = er; stat_rd = rd;
    tmp_wr = tw; tmp_wr_val = tv; fetch_internal = fi;
    bad = pv && !er && ordering_broken(tg, d);
    @(posedge clk);
    #1;
    if (er) begin
      m_glob = 1'b1; m_dbg = 1'b1; m_open = '1; m_close = '1; m_tmp = 1'b0;
    end else begin
      if (pv && !bad) begin
        case (tg)
          2'd0: begin m_glob &= d[0]; m_dbg &= d[1]; end
          2'd1: m_open  &= d;
          2'd2: m_close &= d;
          default: ;
        endcase
      end
      if (tw && fi) m_tmp = tv;
    end
    if (bad) m_err = 1'b1;
    else if (rd) m_err = 1'b0;
    check_all(req);
  endtask

  task automatic prog(input logic [1:0] tg, input logic [N-1:0] d, input string req);
    cycle(1'b1, tg, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic idle_rd(input string req);
    cycle(1'b0, 2'd0, '1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; prog_valid = 0; prog_tgt = 0; prog_data = '1; erase_req = 0;
    stat_rd = 0; tmp_wr = 0; tmp_wr_val = 0; fetch_internal = 0;
    m_glob = 1; m_dbg = 1; m_open = '1; m_close = '1; m_tmp = 0; m_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check_all("R1");

    prog(2'd1, 16'hFFFE, "R3");          // open0 before locks: rejected
    check("R6", "err_raised", 32'(seq_err), 32'd1);
    idle_rd("R6");                       // read clears flag
    check("R6", "err_cleared", 32'(seq_err), 32'd0);
    prog(2'd0, 16'hFFFE, "R2");          // global bit only
    check("R7", "prot_on", 32'(prot_active), 32'd1);
    prog(2'd1, 16'hFFFE, "R3");          // debug still erased
    prog(2'd0, 16'hFFFD, "R2");          // debug bit
    prog(2'd2, 16'hFFFE, "R5");          // close0 before open0
    prog(2'd1, 16'hFFFC, "R6");          // open0 fine, open1 not: whole word dropped
    check("R6", "open_kept", 32'(open_bits), 32'hFFFF);
    prog(2'd1, 16'hFFFE, "R3");          // open0 accepted
    check("R7", "lifted", 32'(prot_active), 32'd0);
    prog(2'd1, 16'hFFFD, "R4");          // open1 before close0
    prog(2'd2, 16'hFFFE, "R5");          // close0 accepted
    check("R7", "restored", 32'(prot_active), 32'd1);
    prog(2'd1, 16'hFFFF, "R2");          // ones change nothing
    prog(2'd3, 16'h0000, "R2");          // reserved target has no effect
    for (int x = 1; x < N; x++) begin
      prog(2'd1, ~(16'h1 << x), "R4");
      check("R7", "pair_lift", 32'(prot_active), 32'd0);
      prog(2'd2, ~(16'h1 << x), "R5");
      check("R7", "pair_close", 32'(prot_active), 32'd1);
    end
    cycle(0, 2'd0, '1, 0, 0, 1, 1, 0, "R8");   // foreign fetch: ignored
    check("R8", "tmp_foreign", 32'(tmp_unlock), 32'd0);
    cycle(0, 2'd0, '1, 0, 0, 1, 1, 1, "R8");   // internal fetch: taken
    check("R7", "tmp_suspend", 32'(prot_active), 32'd0);
    cycle(1, 2'd1, 16'h0000, 1, 0, 1, 1, 1, "R9"); // erase wins
    check("R9", "erase_open", 32'(open_bits), 32'hFFFF);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0]   tg = 2'($urandom_range(0, 3));
      logic [N-1:0] d  = ($urandom_range(0, 9) < 7) ? ~(16'h1 << $urandom_range(0, N-1))
                                                    : 16'($urandom);
      if (tg == 2'd0 && $urandom_range(0, 1) == 0) d = 16'($urandom) | 16'hFFFC;
      cycle($urandom_range(0, 3) != 0, tg, d, $urandom_range(0, 299) == 0,
            $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0,
            1'($urandom), 1'($urandom), "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule